// File: doc/BRIEF.md
# Blit Launch Front End

This block sits between the register write path of a 2D drawing engine and the engine itself. It watches byte writes to a small set of blit registers and turns them into launch events. When software requests a blit, the block looks at the stored mode. It either fires the engine at once for an engine-sourced blit, or it arms a host-to-screen transfer that waits for CPU data. Arming clears the transfer counters downstream and freezes copies of the source and destination addresses. The pixel datapath and the memory interface are outside this block.

A revision input selects between the older and newer feature sets. On the newer revision, writing the top byte of the destination address can start a blit by itself, when an autostart bit is held in the stored start register. The write port is a plain one-cycle strobe with no back-pressure: every strobed byte is taken in the cycle it is presented. The launch outputs are single-cycle pulses or levels, not a stream, so they carry no ready.

Top module: `blit_launch_top`

## Requirements
- R1: After reset, the stored start, mode and extended mode registers read zero, `armed` is low, and neither `run_pulse` nor `ctr_clr` is asserted.
- R2: Every strobed write at offset 0x40 is stored into `start_reg`, whatever its value and whatever the busy state.
- R3: A write at offset 0x40 with data bit 1 set, while mode bit 2 is clear and the engine is idle, raises `run_pulse` for exactly one cycle, in the cycle after the write edge.
- R4: The same request while mode bit 2 (host source) is set instead raises `ctr_clr` for one cycle and sets `armed`. In that same cycle, `dst_snap` and `src_snap` hold the masked destination and the source address that include the bytes written up to and including the write edge.
- R5: On the newer revision (`rev_new` high) only, a write to the top destination byte (offset 0x12) starts a blit exactly as in R3/R4 when bit 7 of the stored start register is set. The snapshot includes the byte just written. On the older revision such a write starts nothing.
- R6: The destination address is built from byte offsets 0x10 (low) to 0x12 (top). `dst_addr` shows it masked to 22 bits when `mem_wide` is high and to 21 bits when it is low.
- R7: A write at offset 0x1b updates `ext_mode` only when `rev_new` is high; otherwise `ext_mode` keeps its value.
- R8: A write at offset 0x1c updates `trans_lo` only when `rev_new` is low; otherwise `trans_lo` keeps its value.
- R9: While `engine_busy` is high, start requests from either path produce neither `run_pulse` nor `ctr_clr`.
- R10: `armed` clears in the cycle after `xfer_done` is seen, unless an arming start happens in that same cycle, in which case `armed` stays high.
- R11: `run_pulse` and `ctr_clr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rev_new | input | 1 | High selects the newer revision feature set |
| mem_wide | input | 1 | High: 22-bit destination addressing; low: 21-bit |
| wr_en | input | 1 | Register write strobe, one byte per cycle |
| wr_ofs | input | 8 | Register offset of the write |
| wr_data | input | 8 | Write data byte |
| engine_busy | input | 1 | Engine is running; start requests are dropped |
| xfer_done | input | 1 | Host transfer has completed; clears `armed` |
| run_pulse | output | 1 | One-cycle command to run an engine-sourced blit |
| armed | output | 1 | Host-to-screen transfer is waiting for CPU data |
| ctr_clr | output | 1 | One-cycle clear for bit, word, pixel and scanline counters |
| dst_addr | output | 22 | Current masked destination address |
| src_addr | output | 22 | Current source address |
| dst_snap | output | 22 | Destination address frozen at the last arming |
| src_snap | output | 22 | Source address frozen at the last arming |
| start_reg | output | 8 | Stored start register |
| mode_reg | output | 8 | Stored mode register (bit 2 selects host source) |
| ext_mode | output | 8 | Stored extended mode register |
| trans_lo | output | 8 | Stored transparency colour low byte |

## Verification
Two functions can meet in the same cycle: the completion of a host transfer (`xfer_done`) and a fresh arming start. The bench drives `xfer_done` high during the very write cycle that re-arms. It then judges that `armed` is still high and that `ctr_clr` fired with fresh snapshots, so that arming is seen to win over clearing. It also writes the top destination byte with autostart enabled and checks that the snapshot already holds that byte, which shows that the address update and the launch take effect at the same edge.

// File: rtl/blit_launch_pkg.sv
package blit_launch_pkg;

  localparam int unsigned OFS_W  = 8;
  localparam int unsigned DATA_W = 8;

  // register offsets; the extended mode and colour byte positions are fixed
  localparam logic [OFS_W-1:0] OFS_DST0     = 8'h10;
  localparam logic [OFS_W-1:0] OFS_SRC0     = 8'h14;
  localparam logic [OFS_W-1:0] OFS_MODE     = 8'h18;
  localparam logic [OFS_W-1:0] OFS_EXT      = 8'h1b;
  localparam logic [OFS_W-1:0] OFS_TRANS_LO = 8'h1c;
  localparam logic [OFS_W-1:0] OFS_START    = 8'h40;

  localparam int unsigned START_REQ_BIT = 1;
  localparam int unsigned AUTO_BIT      = 7;
  localparam int unsigned SYS_SRC_BIT   = 2;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_RUN  = 2'd1,
    ACT_ARM  = 2'd2
  } launch_act_e;

endpackage

// File: rtl/blit_launch_regs.sv
module blit_launch_regs
  import blit_launch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rev_new,
  output logic [DATA_W-1:0] start_q,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] ext_q,
  output logic [DATA_W-1:0] trans_lo_q,
  output logic              start_hit
);

  logic mode_hit, ext_hit, trans_hit;

  always_comb begin
    start_hit = wr_en && (wr_ofs == OFS_START);
    mode_hit  = wr_en && (wr_ofs == OFS_MODE);
    // revision gating of the two version-dependent registers
    ext_hit   = wr_en && (wr_ofs == OFS_EXT) && rev_new;
    trans_hit = wr_en && (wr_ofs == OFS_TRANS_LO) && !rev_new;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q    <= '0;
      mode_q     <= '0;
      ext_q      <= '0;
      trans_lo_q <= '0;
    end else begin
      if (start_hit) start_q    <= wr_data;
      if (mode_hit)  mode_q     <= wr_data;
      if (ext_hit)   ext_q      <= wr_data;
      if (trans_hit) trans_lo_q <= wr_data;
    end
  end

endmodule

// File: rtl/blit_launch_addr.sv
module blit_launch_addr
  import blit_launch_pkg::*;
#(
  parameter int unsigned WIDE_W   = 22,
  parameter int unsigned NARROW_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mem_wide,
  input  logic              snap,
  output logic              dst_top_hit,
  output logic [WIDE_W-1:0] dst_addr,
  output logic [WIDE_W-1:0] src_addr,
  output logic [WIDE_W-1:0] dst_snap,
  output logic [WIDE_W-1:0] src_snap
);

  localparam int unsigned ADDR_BYTES = (WIDE_W + DATA_W - 1) / DATA_W;
  localparam logic [WIDE_W-1:0] MASK_NARROW =
    {{(WIDE_W - NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [WIDE_W-1:0] dst_q, src_q;
  logic [WIDE_W-1:0] dst_nxt, src_nxt;
  logic [WIDE_W-1:0] addr_mask;

  // each byte lane keeps only the bits that fall inside the widest address
  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_lane
    localparam int unsigned LANE_W =
      (WIDE_W - i * DATA_W >= DATA_W) ? DATA_W : (WIDE_W - i * DATA_W);
    logic dst_hit, src_hit;
    assign dst_hit = wr_en && (wr_ofs == OFS_DST0 + OFS_W'(i));
    assign src_hit = wr_en && (wr_ofs == OFS_SRC0 + OFS_W'(i));
    assign dst_nxt[i*DATA_W +: LANE_W] =
      dst_hit ? wr_data[LANE_W-1:0] : dst_q[i*DATA_W +: LANE_W];
    assign src_nxt[i*DATA_W +: LANE_W] =
      src_hit ? wr_data[LANE_W-1:0] : src_q[i*DATA_W +: LANE_W];
  end

  assign dst_top_hit = wr_en && (wr_ofs == OFS_DST0 + OFS_W'(ADDR_BYTES - 1));
  assign addr_mask   = mem_wide ? '1 : MASK_NARROW;
  assign dst_addr    = dst_q & addr_mask;
  assign src_addr    = src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_q    <= '0;
      src_q    <= '0;
      dst_snap <= '0;
      src_snap <= '0;
    end else begin
      dst_q <= dst_nxt;
      src_q <= src_nxt;
      if (snap) begin
        // snapshot sees the byte written in the arming cycle
        dst_snap <= dst_nxt & addr_mask;
        src_snap <= src_nxt;
      end
    end
  end

endmodule

// File: rtl/blit_launch_ctl.sv
module blit_launch_ctl
  import blit_launch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_hit,
  input  logic start_req,
  input  logic dst_top_hit,
  input  logic auto_en,
  input  logic rev_new,
  input  logic sys_src,
  input  logic engine_busy,
  input  logic xfer_done,
  output logic arm_now,
  output logic run_pulse,
  output logic ctr_clr,
  output logic armed
);

  logic        trig;
  launch_act_e act;

  always_comb begin
    trig = 1'b0;
    if (!engine_busy) begin
      if (start_hit && start_req)              trig = 1'b1;
      if (dst_top_hit && rev_new && auto_en)   trig = 1'b1;
    end
    act = ACT_NONE;
    if (trig) act = sys_src ? ACT_ARM : ACT_RUN;
  end

  assign arm_now = (act == ACT_ARM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_pulse <= 1'b0;
      ctr_clr   <= 1'b0;
      armed     <= 1'b0;
    end else begin
      run_pulse <= (act == ACT_RUN);
      ctr_clr   <= arm_now;
      if (arm_now)        armed <= 1'b1;
      else if (xfer_done) armed <= 1'b0;
    end
  end

endmodule

// File: rtl/blit_launch_top.sv
module blit_launch_top
  import blit_launch_pkg::*;
#(
  parameter int unsigned WIDE_W   = 22,
  parameter int unsigned NARROW_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rev_new,
  input  logic              mem_wide,
  input  logic              wr_en,
  input  logic [7:0]        wr_ofs,
  input  logic [7:0]        wr_data,
  input  logic              engine_busy,
  input  logic              xfer_done,
  output logic              run_pulse,
  output logic              armed,
  output logic              ctr_clr,
  output logic [WIDE_W-1:0] dst_addr,
  output logic [WIDE_W-1:0] src_addr,
  output logic [WIDE_W-1:0] dst_snap,
  output logic [WIDE_W-1:0] src_snap,
  output logic [7:0]        start_reg,
  output logic [7:0]        mode_reg,
  output logic [7:0]        ext_mode,
  output logic [7:0]        trans_lo
);

  logic start_hit, dst_top_hit, arm_now;

  blit_launch_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_ofs     (wr_ofs),
    .wr_data    (wr_data),
    .rev_new    (rev_new),
    .start_q    (start_reg),
    .mode_q     (mode_reg),
    .ext_q      (ext_mode),
    .trans_lo_q (trans_lo),
    .start_hit  (start_hit)
  );

  blit_launch_addr #(
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W)
  ) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_ofs      (wr_ofs),
    .wr_data     (wr_data),
    .mem_wide    (mem_wide),
    .snap        (arm_now),
    .dst_top_hit (dst_top_hit),
    .dst_addr    (dst_addr),
    .src_addr    (src_addr),
    .dst_snap    (dst_snap),
    .src_snap    (src_snap)
  );

  blit_launch_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_hit   (start_hit),
    .start_req   (wr_data[START_REQ_BIT]),
    .dst_top_hit (dst_top_hit),
    .auto_en     (start_reg[AUTO_BIT]),
    .rev_new     (rev_new),
    .sys_src     (mode_reg[SYS_SRC_BIT]),
    .engine_busy (engine_busy),
    .xfer_done   (xfer_done),
    .arm_now     (arm_now),
    .run_pulse   (run_pulse),
    .ctr_clr     (ctr_clr),
    .armed       (armed)
  );

endmodule

// File: rtl/blit_launch_chk.sv
module blit_launch_chk #(
  parameter int unsigned WIDE_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rev_new,
  input logic              mem_wide,
  input logic              wr_en,
  input logic [7:0]        wr_ofs,
  input logic              engine_busy,
  input logic              xfer_done,
  input logic              run_pulse,
  input logic              ctr_clr,
  input logic              armed,
  input logic [WIDE_W-1:0] dst_addr,
  input logic [7:0]        ext_mode,
  input logic [7:0]        trans_lo
);

  p_run_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_pulse |-> $past(wr_en && !engine_busy));

  p_arm_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_clr |-> armed);

  p_dst_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wide |-> ((dst_addr >> (WIDE_W - 1)) == '0));

  p_ext_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ofs == 8'h1b && !rev_new) |=> $stable(ext_mode));

  p_trans_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ofs == 8'h1c && rev_new) |=> $stable(trans_lo));

  p_busy_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    engine_busy |=> (!run_pulse && !ctr_clr));

  p_done_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && xfer_done) |=> (armed == ctr_clr));

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_pulse && ctr_clr));

endmodule

bind blit_launch_top blit_launch_chk #(.WIDE_W(WIDE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rev_new     (rev_new),
  .mem_wide    (mem_wide),
  .wr_en       (wr_en),
  .wr_ofs      (wr_ofs),
  .engine_busy (engine_busy),
  .xfer_done   (xfer_done),
  .run_pulse   (run_pulse),
  .ctr_clr     (ctr_clr),
  .armed       (armed),
  .dst_addr    (dst_addr),
  .ext_mode    (ext_mode),
  .trans_lo    (trans_lo)
);

// File: tb/tb_blit_launch_top.sv
`timescale 1ns/1ps
module tb_blit_launch_top;

  localparam int W = 22;

  logic clk = 1'b0;
  logic rst_n, rev_new, mem_wide, wr_en, engine_busy, xfer_done;
  logic [7:0] wr_ofs, wr_data;
  logic run_pulse, armed, ctr_clr;
  logic [W-1:0] dst_addr, src_addr, dst_snap, src_snap;
  logic [7:0] start_reg, mode_reg, ext_mode, trans_lo;

  always #4 clk = ~clk;

  blit_launch_top dut (
    .clk(clk), .rst_n(rst_n), .rev_new(rev_new), .mem_wide(mem_wide),
    .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
    .engine_busy(engine_busy), .xfer_done(xfer_done),
    .run_pulse(run_pulse), .armed(armed), .ctr_clr(ctr_clr),
    .dst_addr(dst_addr), .src_addr(src_addr),
    .dst_snap(dst_snap), .src_snap(src_snap),
    .start_reg(start_reg), .mode_reg(mode_reg),
    .ext_mode(ext_mode), .trans_lo(trans_lo)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          is_arm;
    logic [W-1:0] ds;
    logic [W-1:0] ss;
    string       tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_run(input string tag);
    exp_t e;
    e.is_arm = 1'b0; e.ds = '0; e.ss = '0; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic push_arm(input string tag, input logic [W-1:0] ds, input logic [W-1:0] ss);
    exp_t e;
    e.is_arm = 1'b1; e.ds = ds; e.ss = ss; e.tag = tag;
    sb.push_back(e);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [7:0] o, input logic [7:0] d);
    wr_en = 1'b1; wr_ofs = o; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // scoreboard monitor: every launch must match the oldest expectation
  always @(negedge clk) begin
    if (rst_n === 1'b1 && (run_pulse === 1'b1 || ctr_clr === 1'b1)) begin
      if (sb.size() == 0) begin
        chk("R9 unexpected launch", {30'd0, run_pulse, ctr_clr}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " kind R11"}, {30'd0, run_pulse, ctr_clr}, e.is_arm ? 32'd1 : 32'd2);
        if (e.is_arm) begin
          chk({e.tag, " dst_snap R4"}, 32'(dst_snap), 32'(e.ds));
          chk({e.tag, " src_snap R4"}, 32'(src_snap), 32'(e.ss));
        end
      end
    end
  end

  task automatic run_all();
    rst_n = 1'b0; rev_new = 1'b1; mem_wide = 1'b1; wr_en = 1'b0;
    wr_ofs = '0; wr_data = '0; engine_busy = 1'b0; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 start_reg", 32'(start_reg), 32'h0);
    chk("R1 mode_reg", 32'(mode_reg), 32'h0);
    chk("R1 ext_mode", 32'(ext_mode), 32'h0);
    chk("R1 armed/run/clr", {29'd0, armed, run_pulse, ctr_clr}, 32'h0);

    // R2 every write stored
    wr(8'h40, 8'h80); chk("R2 store 80", 32'(start_reg), 32'h80);
    wr(8'h40, 8'h00); chk("R2 store 00", 32'(start_reg), 32'h00);
    wr(8'h40, 8'h5c); chk("R2 store 5c", 32'(start_reg), 32'h5c);

    // R6 destination assembly and masking (autostart bit clear)
    wr(8'h10, 8'h34); wr(8'h11, 8'h12); wr(8'h12, 8'hff);
    chk("R6 wide mask", 32'(dst_addr), 32'h3f1234);
    mem_wide = 1'b0; #1;
    chk("R6 narrow mask", 32'(dst_addr), 32'h1f1234);
    mem_wide = 1'b1;
    @(negedge clk);

    // R3 immediate run
    wr(8'h18, 8'h00);
    push_run("R3 run");
    wr(8'h40, 8'h02);
    chk("R3 run pulse", 32'(run_pulse), 32'h1);
    @(negedge clk);
    chk("R3 pulse one cycle", 32'(run_pulse), 32'h0);

    // R4 arming with snapshots
    wr(8'h14, 8'haa); wr(8'h15, 8'hbb); wr(8'h16, 8'h2c);
    chk("R4 src_addr", 32'(src_addr), 32'h2cbbaa);
    wr(8'h18, 8'h04);
    push_arm("R4 arm", 22'h3f1234, 22'h2cbbaa);
    wr(8'h40, 8'h02);
    chk("R4 armed", {30'd0, armed, ctr_clr}, 32'h3);
    chk("R11 no run on arm", 32'(run_pulse), 32'h0);
    @(negedge clk);
    chk("R4 clr one cycle, still armed", {30'd0, armed, ctr_clr}, 32'h2);

    // R10 clear, then clear and re-arm in the same cycle
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    chk("R10 done clears", 32'(armed), 32'h0);
    push_arm("R10 rearm", 22'h3f1234, 22'h2cbbaa);
    wr(8'h40, 8'h02);
    chk("R10 armed again", 32'(armed), 32'h1);
    @(negedge clk);
    xfer_done = 1'b1;
    push_arm("R10 collide", 22'h3f1234, 22'h2cbbaa);
    wr(8'h40, 8'h02);
    xfer_done = 1'b0;
    chk("R10 arm wins over done", {30'd0, armed, ctr_clr}, 32'h3);
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    chk("R10 cleared", 32'(armed), 32'h0);

    // R5 autostart on top destination byte
    wr(8'h18, 8'h00);
    wr(8'h40, 8'h80);
    chk("R5 no start from bit7 alone", 32'(run_pulse), 32'h0);
    push_run("R5 auto run");
    wr(8'h12, 8'h01);
    chk("R5 auto run pulse", 32'(run_pulse), 32'h1);
    chk("R5 dst updated", 32'(dst_addr), 32'h011234);
    wr(8'h18, 8'h04);
    push_arm("R5 auto arm", 22'h3c1234, 22'h2cbbaa);
    wr(8'h12, 8'h3c);
    chk("R5 auto arm", 32'(armed), 32'h1);
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    rev_new = 1'b0;
    wr(8'h12, 8'h05);
    chk("R5 old revision no start", {30'd0, run_pulse, ctr_clr}, 32'h0);
    chk("R5 old revision dst written", 32'(dst_addr), 32'h051234);
    rev_new = 1'b1;

    // R7 extended mode gating
    wr(8'h1b, 8'h07); chk("R7 new rev write", 32'(ext_mode), 32'h07);
    rev_new = 1'b0;
    wr(8'h1b, 8'h00); chk("R7 old rev ignored", 32'(ext_mode), 32'h07);

    // R8 transparency low byte gating
    wr(8'h1c, 8'h5a); chk("R8 old rev write", 32'(trans_lo), 32'h5a);
    rev_new = 1'b1;
    wr(8'h1c, 8'h11); chk("R8 new rev ignored", 32'(trans_lo), 32'h5a);

    // R9 busy drops start requests but still stores
    wr(8'h18, 8'h00);
    engine_busy = 1'b1;
    wr(8'h40, 8'h02);
    chk("R9 busy no run", {30'd0, run_pulse, ctr_clr}, 32'h0);
    chk("R9 busy still stored R2", 32'(start_reg), 32'h02);
    wr(8'h40, 8'h82);
    wr(8'h12, 8'h07);
    chk("R9 busy no autostart", {30'd0, run_pulse, ctr_clr}, 32'h0);
    engine_busy = 1'b0;
    @(negedge clk);
    push_run("R9 idle again");
    wr(8'h40, 8'h02);
    chk("R9 run after idle", 32'(run_pulse), 32'h1);
    repeat (2) @(negedge clk);

    chk("scoreboard drained", 32'(sb.size()), 32'h0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule